// File: doc/BRIEF.md
# Three-Floor Lift Motion Controller

This block tracks which of three floors a lift car rests at and turns each floor request into a relative movement command for the drive. The command is one of five one-hot codes: down two floors, down one, stay put, up one or up two. Which code is chosen depends on how far the requested floor lies from the current floor, and in which direction. The command is captured into a register, so the drive sees a steady value. The controller then waits for the drive to report that the move is finished.

Requests enter on a valid/ready handshake. `req_ready` is high exactly when the controller is not busy. A request takes effect only in a cycle where both `req_valid` and `req_ready` are high. There is no back-pressure queue. A request offered while `req_ready` is low is dropped, and the requester must offer it again later. While a move is outstanding, `busy` is high and the command holds its value. The car's position is updated only in the cycle when the drive raises `move_done`.

Top module: `lift_ctrl`

## Requirements
- R1: In the first cycle after synchronous reset, `floor` is 1, `busy` and the stay code are as follows: `busy` is 0 and `cmd` is the stay code 5'b00100.
- R2: An accepted request for the floor the car already occupies leaves `cmd` at the stay code, `busy` low and `floor` unchanged.
- R3: An accepted request for a higher floor makes `busy` high and sets `cmd` at the next clock edge. The code is up1 (5'b01000) when the target is one floor above and up2 (5'b10000) when it is two floors above.
- R4: An accepted request for a lower floor makes `busy` high and sets `cmd` at the next clock edge. The code is down1 (5'b00010) when the target is one floor below and down2 (5'b00001) when it is two floors below.
- R5: While `busy` is high and `move_done` is low, `cmd` and `floor` hold their values.
- R6: A clock edge with `busy` and `move_done` both high does three things. It sets `floor` to the requested floor, clears `busy` and returns `cmd` to the stay code.
- R7: `req_ready` equals the inverse of `busy`. A request offered while busy has no effect on the command or on the floor the car reaches.
- R8: A request vector with zero bits set, or with more than one bit set, causes no command and no change of floor. In `req_vec`, bit 0 requests floor 1, bit 1 requests floor 2 and bit 2 requests floor 3.
- R9: `cmd` always has exactly one bit set. Whenever `busy` is low, that bit is the stay code.
- R10: `move_done` while not busy has no effect. A request vector presented with `req_valid` low also has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_vec | input | 3 | One-hot floor request, bit i means floor i+1 |
| req_ready | output | 1 | Controller can take a request |
| move_done | input | 1 | Drive reports the move is finished |
| cmd | output | 5 | One-hot move: [0] down2, [1] down1, [2] stay, [3] up1, [4] up2 |
| busy | output | 1 | Move outstanding |
| floor | output | 2 | Floor the car rests at, 1 to 3 |

## Verification
The assertions assume that reset is held from time zero until after the first clock edge. They also assume that `move_done` means something only while `busy` is high, and that it may arrive in any cycle, including the cycle right after the command. The stimulus changes inputs only on the falling clock edge. It raises `move_done` only for single cycles, both while a move is outstanding and deliberately while idle. It offers requests while busy and in malformed encodings on purpose, because the assertions are written to hold for those inputs as well.

// File: rtl/lift_pkg.sv
package lift_pkg;
  parameter int DEF_FLOORS = 3;

  function automatic int floor_bits(input int floors);
    return $clog2(floors + 1);
  endfunction

  function automatic int cmd_bits(input int floors);
    return 2 * floors - 1;
  endfunction
endpackage

// File: rtl/lift_req_decode.sv
module lift_req_decode #(
  parameter int FLOORS = lift_pkg::DEF_FLOORS,
  localparam int FW = lift_pkg::floor_bits(FLOORS)
) (
  input  logic [FLOORS-1:0] req_vec,
  output logic              req_ok,
  output logic [FW-1:0]     req_floor
);
  always_comb begin
    req_ok    = ($countones(req_vec) == 1);
    req_floor = '0;
    for (int i = 0; i < FLOORS; i++) begin
      if (req_vec[i]) req_floor = FW'(i + 1);
    end
  end

  always_comb begin
    if (req_ok) begin
      assert (req_floor >= FW'(1) && req_floor <= FW'(FLOORS))
        else $error("p_target_range_r8: decoded floor out of range");
    end
  end
endmodule

// File: rtl/lift_move_calc.sv
module lift_move_calc #(
  parameter int FLOORS = lift_pkg::DEF_FLOORS,
  localparam int FW = lift_pkg::floor_bits(FLOORS),
  localparam int CW = lift_pkg::cmd_bits(FLOORS),
  localparam int IW = $clog2(2 * FLOORS) + 1
) (
  input  logic [FW-1:0] cur_floor,
  input  logic [FW-1:0] tgt_floor,
  output logic [CW-1:0] move_cmd
);
  logic [IW-1:0] slot;

  always_comb begin
    slot = IW'(tgt_floor) + IW'(FLOORS - 1) - IW'(cur_floor);
  end

  for (genvar k = 0; k < CW; k++) begin : g_slot
    assign move_cmd[k] = (slot == IW'(k));
  end
endmodule

// File: rtl/lift_seq.sv
module lift_seq #(
  parameter int FLOORS = lift_pkg::DEF_FLOORS,
  localparam int FW  = lift_pkg::floor_bits(FLOORS),
  localparam int CW  = lift_pkg::cmd_bits(FLOORS),
  localparam int MID = FLOORS - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [FW-1:0] take_floor,
  input  logic [CW-1:0] take_cmd,
  input  logic          move_done,
  output logic [FW-1:0] floor_q,
  output logic          busy_q,
  output logic [CW-1:0] cmd_q
);
  localparam logic [CW-1:0] STAY = CW'(1) << MID;

  logic [FW-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      floor_q <= FW'(1);
      tgt_q   <= FW'(1);
      busy_q  <= 1'b0;
      cmd_q   <= STAY;
    end else if (busy_q) begin
      if (move_done) begin
        floor_q <= tgt_q;
        busy_q  <= 1'b0;
        cmd_q   <= STAY;
      end
    end else if (take && !take_cmd[MID]) begin
      tgt_q  <= take_floor;
      busy_q <= 1'b1;
      cmd_q  <= take_cmd;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q && !move_done |=> busy_q && $stable(cmd_q) && $stable(floor_q));

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q && move_done |=> !busy_q && cmd_q[MID]);

  p_cmd_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(cmd_q) == 1);

  p_idle_stay_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> cmd_q[MID]);

  p_start_move_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !cmd_q[MID] && $stable(floor_q));

  p_idle_done_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_q && !take |=> !busy_q && $stable(floor_q));
endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl #(
  parameter int FLOORS = lift_pkg::DEF_FLOORS,
  localparam int FW  = lift_pkg::floor_bits(FLOORS),
  localparam int CW  = lift_pkg::cmd_bits(FLOORS),
  localparam int MID = FLOORS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [FLOORS-1:0] req_vec,
  output logic              req_ready,
  input  logic              move_done,
  output logic [CW-1:0]     cmd,
  output logic              busy,
  output logic [FW-1:0]     floor
);
  logic          req_ok;
  logic [FW-1:0] req_floor;
  logic [CW-1:0] move_cmd;
  logic          take;

  lift_req_decode #(.FLOORS(FLOORS)) u_decode (
    .req_vec   (req_vec),
    .req_ok    (req_ok),
    .req_floor (req_floor)
  );

  lift_move_calc #(.FLOORS(FLOORS)) u_calc (
    .cur_floor (floor),
    .tgt_floor (req_floor),
    .move_cmd  (move_cmd)
  );

  assign req_ready = !busy;
  assign take      = req_valid && req_ready && req_ok;

  lift_seq #(.FLOORS(FLOORS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .take_floor (req_floor),
    .take_cmd   (move_cmd),
    .move_done  (move_done),
    .floor_q    (floor),
    .busy_q     (busy),
    .cmd_q      (cmd)
  );

  p_bad_vec_r8: assert property (@(posedge clk) disable iff (rst)
    !busy && req_valid && $countones(req_vec) != 1 |=> !busy && $stable(floor));

  p_same_floor_r2: assert property (@(posedge clk) disable iff (rst)
    !busy && req_valid && req_ok && req_floor == floor |=> !busy && cmd[MID]);

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);
endmodule

// File: tb/lift_ctrl_bench.sv
module lift_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_vec = 3'b000;
  logic       move_done = 1'b0;
  logic       req_ready;
  logic [4:0] cmd;
  logic       busy;
  logic [1:0] floor;

  int n_checks = 0;
  int n_errors = 0;
  int exp_floor = 1;

  localparam logic [4:0] STAY = 5'b00100;

  always #4 clk = ~clk;

  lift_ctrl u_lift_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
    .req_ready(req_ready), .move_done(move_done), .cmd(cmd),
    .busy(busy), .floor(floor)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_code(input int cur, input int tgt);
    return 5'b00001 << (2 + tgt - cur);
  endfunction

  task automatic offer(input logic [2:0] v, input logic vld);
    @(negedge clk);
    req_vec = v; req_valid = vld;
    @(negedge clk);
    req_valid = 1'b0; req_vec = 3'b000;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    move_done = 1'b1;
    @(negedge clk);
    move_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "floor", floor, 1);
    check("R1", "busy", busy, 0);
    check("R1", "cmd", cmd, STAY);
    check("R7", "ready idle", req_ready, 1);
  endtask

  task automatic t_move(input int tgt, input string tag, input int hold);
    logic [4:0] want;
    want = exp_code(exp_floor, tgt);
    offer(3'b001 << (tgt - 1), 1'b1);
    check(tag, "cmd", cmd, want);
    check(tag, "busy", busy, 1);
    check("R7", "ready busy", req_ready, 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R5", "cmd held", cmd, want);
      check("R5", "floor held", floor, exp_floor);
    end
    pulse_done();
    exp_floor = tgt;
    check("R6", "floor", floor, exp_floor);
    check("R6", "busy", busy, 0);
    check("R6", "cmd", cmd, STAY);
  endtask

  task automatic t_same_floor();
    offer(3'b001 << (exp_floor - 1), 1'b1);
    check("R2", "cmd", cmd, STAY);
    check("R2", "busy", busy, 0);
    check("R2", "floor", floor, exp_floor);
  endtask

  task automatic t_busy_ignore();
    logic [4:0] want;
    want = exp_code(exp_floor, 3);
    offer(3'b100, 1'b1);
    offer(3'b010, 1'b1);
    check("R7", "cmd while busy req", cmd, want);
    offer(3'b001, 1'b1);
    check("R7", "cmd still", cmd, want);
    pulse_done();
    exp_floor = 3;
    check("R7", "floor after ignored", floor, 3);
    check("R7", "busy", busy, 0);
  endtask

  task automatic t_bad_vec(input logic [2:0] v);
    offer(v, 1'b1);
    check("R8", "cmd", cmd, STAY);
    check("R8", "busy", busy, 0);
    check("R8", "floor", floor, exp_floor);
  endtask

  task automatic t_ignored_inputs();
    pulse_done();
    check("R10", "done idle floor", floor, exp_floor);
    check("R10", "done idle busy", busy, 0);
    offer(3'b100 >> (exp_floor == 3 ? 2 : 0), 1'b0);
    check("R10", "no valid cmd", cmd, STAY);
    check("R10", "no valid busy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_same_floor();
    t_move(3, "R3", 3);
    t_move(2, "R4", 0);
    t_move(3, "R3", 1);
    t_move(1, "R4", 2);
    t_move(2, "R3", 0);
    t_move(1, "R4", 1);
    t_busy_ignore();
    t_same_floor();
    t_bad_vec(3'b000);
    t_bad_vec(3'b011);
    t_bad_vec(3'b111);
    t_bad_vec(3'b101);
    t_ignored_inputs();
    t_move(1, "R4", 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule